// File: doc/BRIEF.md
# Calendar Real-Time Clock with Alarm

This block keeps a wall-clock calendar made of seconds, minutes, hours, a day of the week, a day of the month, a month, and a two-digit year counted from 2000. A one-cycle pulse on `tick_i`, arriving once per second, moves the calendar forward. A second bank of seven fields holds an alarm time. When the calendar steps onto the alarm time while the alarm is armed, a sticky status bit is set and the interrupt line goes high.

Software reaches the block through a plain 32-bit register port with byte addresses. Reads are combinational and always permitted. Writes to the control, calendar and alarm registers are dropped until software has written a fixed seven-step key sequence. To load a new time, software sets the freeze bit, rewrites the fields, and then clears the bit so counting resumes.

Top module: `cal_rtc`

## Requirements
- R1: After reset, the register reads are as follows: the freeze bit at 0x20 reads 1, the alarm control at 0x7C reads 0, the status at 0x30 reads 0, and `irq_o` is 0. The live calendar fields sit at byte address 0x40 + 4*i, where i = 0 year, 1 month, 2 day of month, 3 day of week, 4 hour, 5 minute, 6 second. After reset they read year 0, month 1, day 1, day of week 0, 00:00:00. The alarm fields use the same index at 0x60 + 4*i.
- R2: Writes to 0x20 and to 0x40..0x7C have no effect until the key sequence has been completed. The sequence is 0xC6→0x04, 0x9A→0x08, 0x59→0x0C, 0xA3→0x10, 0x57→0x14, 0x67→0x18, 0xD2→0x1C, written in that order with the full 32-bit data equal to the key. Once complete, the port stays open until reset.
- R3: The partial sequence returns to its first step in two cases: a key-address write with the wrong value or out of order, or a write to a protected register before the sequence is complete.
- R4: While bit 0 of 0x20 is 1, tick pulses leave the calendar unchanged. When the bit is 0, each tick advances the calendar by one second.
- R5: On a tick, the second rolls from 59 to 0 and carries into the minute. The minute rolls from 59 to 0 and carries into the hour. The hour rolls from 23 to 0 and carries into the day.
- R6: A day carry past the last day of the month sets the day of month to 1 and advances the month. Months 4, 6, 9 and 11 have 30 days; the other months, except February, have 31. Month 12 wraps to 1 and advances the year.
- R7: February has 29 days when the year value is a nonzero multiple of 4. Otherwise it has 28, and this includes year 0.
- R8: The year advances from 99 to 0.
- R9: Every day carry advances the day of week from 0 to 6 and then back to 0.
- R10: The status bit (bit 4 of 0x30) is set on the tick edge at which the calendar takes a value equal to all seven alarm fields, provided bit 0 of 0x7C is 1. If that bit is 0, no status is raised.
- R11: `irq_o` is the status bit gated by bit 0 of 0x7C. Writing 0x00 to 0x7C drops the interrupt. Writing 0xFF arms the alarm, and 0x7C then reads back 0xFF.
- R12: Writing data with bit 4 set to 0x30 clears the status bit. Writing data with bit 4 clear leaves it unchanged. If a new match falls in the same cycle as a clear, the status bit stays set.
- R13: If a tick arrives in the same cycle as an effective write to a live calendar field, the tick is lost. The written value is stored and no other field moves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse, once per second |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Byte address of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| irq_o | output | 1 | Alarm interrupt |

## Verification
The assertions check five rules on every cycle:
- the calendar stays frozen while the freeze bit is set;
- each counted tick steps the second field correctly;
- locked writes cannot move the freeze bit, and the unlocked state never falls back;
- status only rises on a tick, a disarm always drops the interrupt, and a clear works whenever no tick competes with it;
- a colliding tick is lost in favour of the written second.

Month lengths, leap-year handling, the year wrap, the day-of-week cycle and a full seven-field alarm match only show up in the bench's scenarios. The same applies to the restart behaviour of a broken key sequence.

// File: rtl/rtc_pkg.sv
// Shared types and helpers for the calendar RTC.
// Assumes an 8-bit-or-wider byte address and 32-bit data.
package rtc_pkg;

    typedef struct packed {
        logic [6:0] year;
        logic [3:0] mon;
        logic [4:0] dom;
        logic [2:0] dow;
        logic [4:0] hour;
        logic [5:0] min;
        logic [5:0] sec;
    } cal_t;

    localparam int UNLOCK_LEN = 7;
    localparam logic [7:0] OFS_CTL    = 8'h20;
    localparam logic [7:0] OFS_STAT   = 8'h30;
    localparam logic [7:0] OFS_LIVE   = 8'h40;
    localparam logic [7:0] OFS_ALM    = 8'h60;
    localparam logic [7:0] OFS_KEY0   = 8'h04;
    localparam int         STAT_BIT   = 4;

    // Address of key step i: one word per step starting at 0x04.
    function automatic logic [7:0] key_addr(input logic [2:0] i);
        return OFS_KEY0 + {3'b000, i, 2'b00};
    endfunction

    // Value expected at key step i.
    function automatic logic [7:0] key_val(input logic [2:0] i);
        case (i)
            3'd0:    return 8'hC6;
            3'd1:    return 8'h9A;
            3'd2:    return 8'h59;
            3'd3:    return 8'hA3;
            3'd4:    return 8'h57;
            3'd5:    return 8'h67;
            default: return 8'hD2;
        endcase
    endfunction

    // Number of days in month m of year y (year 0 is a common year).
    function automatic logic [4:0] month_len(input logic [3:0] m, input logic [6:0] y);
        logic leap;
        leap = (y[1:0] == 2'b00) && (y != 7'd0);
        case (m)
            4'd2:                      return leap ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
            default:                   return 5'd31;
        endcase
    endfunction

    // Field i of a calendar value, zero-extended to 7 bits.
    function automatic logic [6:0] get_field(input cal_t c, input logic [2:0] i);
        case (i)
            3'd0:    return c.year;
            3'd1:    return {3'b000, c.mon};
            3'd2:    return {2'b00, c.dom};
            3'd3:    return {4'b0000, c.dow};
            3'd4:    return {2'b00, c.hour};
            3'd5:    return {1'b0, c.min};
            3'd6:    return {1'b0, c.sec};
            default: return 7'd0;
        endcase
    endfunction

    // Copy of c with field i replaced by v (truncated to the field width).
    function automatic cal_t set_field(input cal_t c, input logic [2:0] i, input logic [6:0] v);
        cal_t r;
        r = c;
        case (i)
            3'd0:    r.year = v;
            3'd1:    r.mon  = v[3:0];
            3'd2:    r.dom  = v[4:0];
            3'd3:    r.dow  = v[2:0];
            3'd4:    r.hour = v[4:0];
            3'd5:    r.min  = v[5:0];
            3'd6:    r.sec  = v[5:0];
            default: r = c;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rtc_unlock.sv
// Key-sequence gate. Tracks how many key writes have arrived in order
// and opens once all of them have. A wrong key, an out-of-order key, or
// a protected write before completion returns to step 0. Stays open
// until reset. Assumes protected space is 0x20 and 0x40..0x7F.
module rtc_unlock #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [31:0]       wdata_i,
    output logic              open_o
);
    import rtc_pkg::*;

    localparam int STEP_W = $clog2(UNLOCK_LEN + 1);

    logic [STEP_W-1:0] step_q;
    logic              is_key, is_prot, key_ok;

    // Decode key-window and protected-window hits for this write.
    always_comb begin
        is_key  = (addr_i >= ADDR_W'(key_addr(3'd0))) &&
                  (addr_i <= ADDR_W'(key_addr(3'(UNLOCK_LEN - 1)))) &&
                  (addr_i[1:0] == 2'b00);
        is_prot = (addr_i == ADDR_W'(OFS_CTL)) ||
                  ((addr_i >= ADDR_W'(OFS_LIVE)) && (addr_i <= ADDR_W'(8'h7F)));
        key_ok  = (addr_i == ADDR_W'(key_addr(3'(step_q)))) &&
                  (wdata_i == 32'(key_val(3'(step_q))));
    end

    assign open_o = (step_q == STEP_W'(UNLOCK_LEN));

    // Advance, restart or hold the key step counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
        end else if (wr_i && !open_o) begin
            if (is_key)
                step_q <= key_ok ? step_q + 1'b1 : '0;
            else if (is_prot)
                step_q <= '0;
        end
    end

endmodule

// File: rtl/rtc_calendar.sv
// Live calendar counter. Advances by one second on a counted tick
// (tick, not frozen, no field write in the same cycle) and accepts
// software field writes. Also presents the advanced value so that the
// alarm can compare against it on the same edge. Assumes fields are
// written in range.
module rtc_calendar #(
    parameter int YEAR_MAX = 99
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          stop_i,
    input  logic          wr_i,
    input  logic [2:0]    wr_idx_i,
    input  logic [6:0]    wr_val_i,
    output rtc_pkg::cal_t now_o,
    output rtc_pkg::cal_t next_o,
    output logic          adv_o
);
    import rtc_pkg::*;

    localparam logic [5:0] SEC_LAST  = 6'd59;
    localparam logic [5:0] MIN_LAST  = 6'd59;
    localparam logic [4:0] HOUR_LAST = 5'd23;
    localparam logic [2:0] DOW_LAST  = 3'd6;
    localparam logic [3:0] MON_LAST  = 4'd12;
    localparam logic [6:0] YEAR_LAST = 7'(YEAR_MAX);

    cal_t now_q, nx;
    logic day_roll;

    assign adv_o  = tick_i && !stop_i && !wr_i;
    assign now_o  = now_q;
    assign next_o = nx;

    // Compute the calendar one second later, carrying field by field.
    always_comb begin
        nx       = now_q;
        day_roll = 1'b0;
        if (now_q.sec >= SEC_LAST) begin
            nx.sec = 6'd0;
            if (now_q.min >= MIN_LAST) begin
                nx.min = 6'd0;
                if (now_q.hour >= HOUR_LAST) begin
                    nx.hour  = 5'd0;
                    day_roll = 1'b1;
                end else begin
                    nx.hour = now_q.hour + 5'd1;
                end
            end else begin
                nx.min = now_q.min + 6'd1;
            end
        end else begin
            nx.sec = now_q.sec + 6'd1;
        end
        if (day_roll) begin
            nx.dow = (now_q.dow >= DOW_LAST) ? 3'd0 : now_q.dow + 3'd1;
            if (now_q.dom >= month_len(now_q.mon, now_q.year)) begin
                nx.dom = 5'd1;
                if (now_q.mon >= MON_LAST) begin
                    nx.mon  = 4'd1;
                    nx.year = (now_q.year >= YEAR_LAST) ? 7'd0 : now_q.year + 7'd1;
                end else begin
                    nx.mon = now_q.mon + 4'd1;
                end
            end else begin
                nx.dom = now_q.dom + 5'd1;
            end
        end
    end

    // Hold, load a field, or advance the calendar.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now_q      <= '0;
            now_q.mon  <= 4'd1;
            now_q.dom  <= 5'd1;
        end else if (wr_i) begin
            now_q <= set_field(now_q, wr_idx_i, wr_val_i);
        end else if (adv_o) begin
            now_q <= nx;
        end
    end

endmodule

// File: rtl/cal_rtc.sv
// Calendar RTC top. Register decode, freeze bit, alarm field bank,
// alarm control byte, sticky alarm status and interrupt. Reads are
// combinational. Writes other than the status clear need the key gate.
module cal_rtc #(
    parameter int ADDR_W   = 8,
    parameter int YEAR_MAX = 99
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              irq_o
);
    import rtc_pkg::*;

    localparam logic [2:0] CTL_IDX = 3'd7;

    logic       unlocked, stop_q, status_q, adv;
    logic [7:0] almctl_q;
    cal_t       now_q, next_c, alm_q;
    logic       in_live, in_alm, is_almctl, live_wr, wr_ok, match, clr_req;
    logic [2:0] idx;

    // Window decode: live bank 0x40..0x58, alarm bank 0x60..0x78, alarm control 0x7C.
    always_comb begin
        idx       = bus_addr_i[4:2];
        in_live   = ((bus_addr_i & ~ADDR_W'(8'h1F)) == ADDR_W'(OFS_LIVE)) &&
                    (bus_addr_i[1:0] == 2'b00) && (idx != CTL_IDX);
        in_alm    = ((bus_addr_i & ~ADDR_W'(8'h1F)) == ADDR_W'(OFS_ALM)) &&
                    (bus_addr_i[1:0] == 2'b00) && (idx != CTL_IDX);
        is_almctl = (bus_addr_i == ADDR_W'(OFS_ALM + 8'h1C));
        wr_ok     = bus_wr_i && unlocked;
        live_wr   = wr_ok && in_live;
        clr_req   = bus_wr_i && (bus_addr_i == ADDR_W'(OFS_STAT)) && bus_wdata_i[STAT_BIT];
        match     = adv && almctl_q[0] && (next_c == alm_q);
    end

    rtc_unlock #(.ADDR_W(ADDR_W)) u_unlock (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .open_o  (unlocked)
    );

    rtc_calendar #(.YEAR_MAX(YEAR_MAX)) u_cal (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .stop_i   (stop_q),
        .wr_i     (live_wr),
        .wr_idx_i (idx),
        .wr_val_i (bus_wdata_i[6:0]),
        .now_o    (now_q),
        .next_o   (next_c),
        .adv_o    (adv)
    );

    // Freeze bit, alarm bank and alarm control: written only when unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_q   <= 1'b1;
            alm_q    <= '0;
            almctl_q <= 8'h00;
        end else if (wr_ok) begin
            if (bus_addr_i == ADDR_W'(OFS_CTL)) stop_q   <= bus_wdata_i[0];
            if (in_alm)                         alm_q    <= set_field(alm_q, idx, bus_wdata_i[6:0]);
            if (is_almctl)                      almctl_q <= bus_wdata_i[7:0];
        end
    end

    // Sticky alarm status: a new match wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       status_q <= 1'b0;
        else if (match)   status_q <= 1'b1;
        else if (clr_req) status_q <= 1'b0;
    end

    assign irq_o = status_q && almctl_q[0];

    // Combinational read mux.
    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == ADDR_W'(OFS_CTL))       bus_rdata_o[0]        = stop_q;
        else if (bus_addr_i == ADDR_W'(OFS_STAT)) bus_rdata_o[STAT_BIT] = status_q;
        else if (in_live)                         bus_rdata_o[6:0]      = get_field(now_q, idx);
        else if (in_alm)                          bus_rdata_o[6:0]      = get_field(alm_q, idx);
        else if (is_almctl)                       bus_rdata_o[7:0]      = almctl_q;
    end

endmodule

// File: rtl/rtc_checker.sv
// Temporal checks on the calendar RTC, bound into every cal_rtc instance.
module rtc_checker #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic              bus_wr_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [5:0]        wdata_lo,
    input logic              irq_o,
    input logic              unlocked,
    input logic              stop_q,
    input logic              status_q,
    input rtc_pkg::cal_t     now_q
);
    import rtc_pkg::*;

    // R2: a locked write to the control register cannot move the freeze bit.
    assert_locked_ctl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && bus_wr_i && bus_addr_i == ADDR_W'(OFS_CTL)) |=> $stable(stop_q));

    // R2: once open, the gate stays open.
    assert_unlock_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        unlocked |=> unlocked);

    // R4: while frozen and without a write, the calendar holds.
    assert_frozen_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_q && !bus_wr_i) |=> $stable(now_q));

    // R5: a counted tick steps the second field by one, rolling after 59.
    assert_sec_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !stop_q && !bus_wr_i) |=>
        (now_q.sec == (($past(now_q.sec) >= 6'd59) ? 6'd0 : $past(now_q.sec) + 6'd1)));

    // R10: the status bit only rises on a tick.
    assert_status_on_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q) |-> $past(tick_i));

    // R11: disarming the alarm drops the interrupt.
    assert_disarm_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && unlocked && bus_addr_i == ADDR_W'(OFS_ALM + 8'h1C) && !wdata_lo[0]) |=> !irq_o);

    // R12: a clear without a competing tick empties the status bit.
    assert_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_i && bus_addr_i == ADDR_W'(OFS_STAT) && wdata_lo[STAT_BIT] && !tick_i) |=> !status_q);

    // R13: a tick colliding with a seconds write is lost; the written value is kept.
    assert_tick_drop_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && bus_wr_i && unlocked && bus_addr_i == ADDR_W'(OFS_LIVE + 8'h18)) |=>
        (now_q.sec == $past(wdata_lo)));

endmodule

bind cal_rtc rtc_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .bus_wr_i   (bus_wr_i),
    .bus_addr_i (bus_addr_i),
    .wdata_lo   (bus_wdata_i[5:0]),
    .irq_o      (irq_o),
    .unlocked   (unlocked),
    .stop_q     (stop_q),
    .status_q   (status_q),
    .now_q      (now_q)
);

// File: tb/cal_rtc_tb.sv
`timescale 1ns/1ps
module cal_rtc_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tk = 1'b0;
    logic        bwr = 1'b0;
    logic [7:0]  baddr = 8'h00;
    logic [31:0] bwdata = 32'h0;
    logic [31:0] rdata;
    logic        irq;
    int          n_chk = 0;
    int          n_bad = 0;
    logic        done = 1'b0;

    always #10 clk = ~clk;

    cal_rtc u_dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tk), .bus_wr_i(bwr),
        .bus_addr_i(baddr), .bus_wdata_i(bwdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    // Packed time: year7 mon4 dom5 dow3 hour5 min6 sec6.
    function automatic logic [35:0] tp(int y, int mo, int d, int w, int h, int mi, int s);
        return {7'(y), 4'(mo), 5'(d), 3'(w), 5'(h), 6'(mi), 6'(s)};
    endfunction

    localparam int NV = 13;
    localparam logic [71:0] VEC [NV] = '{
        {tp(1,3,15,2,10,20,30), tp(1,3,15,2,10,20,31)},  // R5 plain second
        {tp(1,3,15,2,10,20,59), tp(1,3,15,2,10,21,0)},   // R5 minute carry
        {tp(1,3,15,2,10,59,59), tp(1,3,15,2,11,0,0)},    // R5 hour carry
        {tp(1,3,15,2,23,59,59), tp(1,3,16,3,0,0,0)},     // R5 R9 day carry
        {tp(1,1,31,6,23,59,59), tp(1,2,1,0,0,0,0)},      // R6 R9 31-day month, dow wrap
        {tp(4,2,28,1,23,59,59), tp(4,2,29,2,0,0,0)},     // R7 leap Feb 28
        {tp(4,2,29,2,23,59,59), tp(4,3,1,3,0,0,0)},      // R7 leap Feb 29
        {tp(0,2,28,0,23,59,59), tp(0,3,1,1,0,0,0)},      // R7 year 0 common
        {tp(5,2,28,3,23,59,59), tp(5,3,1,4,0,0,0)},      // R7 common year
        {tp(7,4,30,4,23,59,59), tp(7,5,1,5,0,0,0)},      // R6 30-day month end
        {tp(7,4,29,4,23,59,59), tp(7,4,30,5,0,0,0)},     // R6 30-day month inside
        {tp(99,12,31,5,23,59,59), tp(0,1,1,6,0,0,0)},    // R8 year wrap
        {tp(20,12,31,6,23,59,59), tp(21,1,1,0,0,0,0)}    // R6 year advance
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bwr = 1'b1; baddr = a; bwdata = d;
        @(negedge clk); bwr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk); baddr = a; #1; v = rdata;
    endtask

    task automatic tick();
        @(negedge clk); tk = 1'b1;
        @(negedge clk); tk = 1'b0;
    endtask

    task automatic unlock(input int from, input int upto);
        for (int i = from; i < upto; i++) begin
            logic [7:0] kv;
            case (i)
                0: kv = 8'hC6; 1: kv = 8'h9A; 2: kv = 8'h59; 3: kv = 8'hA3;
                4: kv = 8'h57; 5: kv = 8'h67; default: kv = 8'hD2;
            endcase
            wr(8'(8'h04 + 4 * i), {24'h0, kv});
        end
    endtask

    task automatic set_bank(input logic [7:0] base, input logic [35:0] t);
        wr(base + 8'h00, 32'(t[35:29]));
        wr(base + 8'h04, 32'(t[28:25]));
        wr(base + 8'h08, 32'(t[24:20]));
        wr(base + 8'h0C, 32'(t[19:17]));
        wr(base + 8'h10, 32'(t[16:12]));
        wr(base + 8'h14, 32'(t[11:6]));
        wr(base + 8'h18, 32'(t[5:0]));
    endtask

    task automatic get_time(output logic [35:0] t);
        logic [31:0] v;
        rd(8'h40, v); t[35:29] = v[6:0];
        rd(8'h44, v); t[28:25] = v[3:0];
        rd(8'h48, v); t[24:20] = v[4:0];
        rd(8'h4C, v); t[19:17] = v[2:0];
        rd(8'h50, v); t[16:12] = v[4:0];
        rd(8'h54, v); t[11:6]  = v[5:0];
        rd(8'h58, v); t[5:0]   = v[5:0];
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [35:0] t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h20, v); chk("R1 freeze bit", v, 32'h1);
        rd(8'h7C, v); chk("R1 alarm ctl", v, 32'h0);
        rd(8'h30, v); chk("R1 status", v, 32'h0);
        chk("R1 irq", irq, 1'b0);
        get_time(t);  chk("R1 calendar", t, tp(0,1,1,0,0,0,0));

        // R2 locked writes ignored
        wr(8'h58, 32'd5);
        rd(8'h58, v); chk("R2 locked sec write", v, 32'd0);
        wr(8'h20, 32'd0); tick();
        rd(8'h20, v); chk("R2 locked ctl write", v, 32'h1);
        rd(8'h58, v); chk("R2 R4 no count while locked", v, 32'd0);

        // R3 wrong key restarts
        unlock(0, 3); wr(8'h10, 32'h00); unlock(3, 7);
        wr(8'h58, 32'd9);
        rd(8'h58, v); chk("R3 wrong key", v, 32'd0);
        // R3 protected write mid-sequence restarts
        unlock(0, 3); wr(8'h44, 32'd2); unlock(3, 7);
        wr(8'h58, 32'd9);
        rd(8'h58, v); chk("R3 stray write", v, 32'd0);
        rd(8'h44, v); chk("R3 stray write month", v, 32'd1);

        // R2 full sequence opens the port
        unlock(0, 7);
        wr(8'h58, 32'd9);
        rd(8'h58, v); chk("R2 unlocked write", v, 32'd9);

        // R4 freeze
        tick(); rd(8'h58, v); chk("R4 frozen tick", v, 32'd9);
        wr(8'h20, 32'd0); tick();
        rd(8'h58, v); chk("R4 running tick", v, 32'd10);
        wr(8'h20, 32'd1);

        // Table walk: R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            set_bank(8'h40, VEC[i][71:36]);
            wr(8'h20, 32'd0); tick(); wr(8'h20, 32'd1);
            get_time(t);
            chk($sformatf("vector %0d calendar step", i), t, VEC[i][35:0]);
        end

        // R10 R11 alarm match
        set_bank(8'h40, tp(1,3,15,2,10,20,30));
        set_bank(8'h60, tp(1,3,15,2,10,20,31));
        wr(8'h7C, 32'hFF);
        rd(8'h7C, v); chk("R11 arm readback", v, 32'hFF);
        chk("R11 irq before match", irq, 1'b0);
        wr(8'h20, 32'd0); tick(); wr(8'h20, 32'd1);
        rd(8'h30, v); chk("R10 status on match", v, 32'h10);
        chk("R11 irq on match", irq, 1'b1);

        // R12 write-one-to-clear
        wr(8'h30, 32'h0);
        rd(8'h30, v); chk("R12 zero write keeps", v, 32'h10);
        wr(8'h30, 32'h10);
        rd(8'h30, v); chk("R12 clear", v, 32'h0);
        chk("R12 irq after clear", irq, 1'b0);

        // R10 disabled alarm does not raise status
        set_bank(8'h40, tp(1,3,15,2,10,20,30));
        wr(8'h7C, 32'h00);
        wr(8'h20, 32'd0); tick(); wr(8'h20, 32'd1);
        rd(8'h30, v); chk("R10 disabled no status", v, 32'h0);

        // R12 match beats a clear in the same cycle
        set_bank(8'h40, tp(1,3,15,2,10,20,30));
        wr(8'h7C, 32'hFF); wr(8'h20, 32'd0);
        @(negedge clk); tk = 1'b1; bwr = 1'b1; baddr = 8'h30; bwdata = 32'h10;
        @(negedge clk); tk = 1'b0; bwr = 1'b0;
        wr(8'h20, 32'd1);
        rd(8'h30, v); chk("R12 set wins over clear", v, 32'h10);

        // R11 disarm drops the interrupt but keeps status
        wr(8'h7C, 32'h00);
        chk("R11 irq after disarm", irq, 1'b0);
        rd(8'h30, v); chk("R11 status kept after disarm", v, 32'h10);

        // R13 tick colliding with a seconds write is lost
        set_bank(8'h40, tp(1,3,15,2,10,20,59));
        wr(8'h20, 32'd0);
        @(negedge clk); tk = 1'b1; bwr = 1'b1; baddr = 8'h58; bwdata = 32'd40;
        @(negedge clk); tk = 1'b0; bwr = 1'b0;
        wr(8'h20, 32'd1);
        get_time(t); chk("R13 tick dropped", t, tp(1,3,15,2,10,20,40));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule